// File: doc/BRIEF.md
# Logical and Arithmetic Barrel Shifter

This block is a purely combinational 32-bit shifter that sits next to the integer ALU of a simple processor datapath. It takes an operand word, a 5-bit shift count taken from the shift-amount field of a register-format instruction, and the 6-bit function field of that instruction. It returns the shifted word together with a flag that says whether the function field named one of the three supported shifts.

Three operations are supported: a left shift that fills with zeros, a right shift that fills with zeros, and a right shift that fills the vacated upper bits with the operand's original most significant bit, so that a signed value is divided by a power of two. There is no signed left shift, because a zero-filling left shift already doubles a two's complement number. The shifter is built as a logarithmic network of five multiplexer layers that move the word by 1, 2, 4, 8 and 16 places, each layer enabled by one bit of the count.

Top module: `barrel_shifter`

## Requirements
- R1: Function field 6'b000000 selects a left shift by the count; the low bits that become empty are filled with 0.
- R2: Function field 6'b000010 selects a right shift by the count; the high bits that become empty are filled with 0.
- R3: Function field 6'b000011 selects a right shift by the count in which every emptied high bit takes the value of bit 31 of the operand; with count 31 a negative operand yields all ones and a non-negative one yields 0.
- R4: Every count from 0 to 31 is honoured for all three shifts, and a count of 0 returns the operand unchanged.
- R5: Any function field other than the three above forces the result to 32'h0 and the valid flag to 0; this includes 6'b000001, so no signed left shift exists.
- R6: The valid flag is 1 exactly when the function field is one of the three supported codes.
- R7: A count of 8 moves whole bytes: 32'h12345678 shifted left gives 32'h34567800, shifted right gives 32'h00123456, and 32'h87654321 shifted right with sign fill gives 32'hFF876543.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 32 | Word to be shifted |
| shiftCount | input | 5 | Number of places to shift, 0 to 31 |
| funcCode | input | 6 | Instruction function field selecting the shift kind |
| shiftResult | output | 32 | Shifted word, or 0 for an unknown code |
| resultValid | output | 1 | High when funcCode is a supported shift |

## Verification
The bench sweeps every count for each shift over operands with the top bit set and clear, since a design that took the fill bit from an intermediate layer instead of the original operand, or that wired one layer to the wrong count bit, would go wrong only at particular counts or signs. Count 31 and count 0 are the edges where a layer that drops or duplicates a bit shows up, and a byte-sized move of 8 catches a mis-sized middle layer. Every other function field, including the neighbour of the left-shift code, is applied to check that the result is cleared and the flag drops rather than some shift leaking through.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int DATA_W = 32;
  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_LEFT_ZERO  = 6'b000000;
  localparam logic [FUNC_W-1:0] FN_RIGHT_ZERO = 6'b000010;
  localparam logic [FUNC_W-1:0] FN_RIGHT_SIGN = 6'b000011;

  typedef struct packed {
    logic enable;     // supported operation, drive the result
    logic toLeft;     // shift towards the high end
    logic signFill;   // replicate operand bit DATA_W-1 into emptied bits
  } shift_ctrl_t;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shifter_pkg::*;
#(
  parameter int FW = FUNC_W
) (
  input  logic [FW-1:0] funcCode,
  output shift_ctrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (funcCode)
      FN_LEFT_ZERO: begin
        ctrl.enable = 1'b1;
        ctrl.toLeft = 1'b1;
      end
      FN_RIGHT_ZERO: begin
        ctrl.enable = 1'b1;
      end
      FN_RIGHT_SIGN: begin
        ctrl.enable   = 1'b1;
        ctrl.signFill = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int AW = $clog2(DW)
) (
  input  logic [DW-1:0] dataIn,
  input  logic [AW-1:0] amount,
  input  shift_ctrl_t   ctrl,
  output logic [DW-1:0] dataOut
);
  function automatic logic [DW-1:0] mirror(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = w[DW-1-i];
    return r;
  endfunction

  logic              fillBit;
  logic [DW-1:0]     layer [AW+1];
  logic [DW-1:0]     rightOut;

  assign fillBit  = ctrl.signFill & dataIn[DW-1];
  assign layer[0] = ctrl.toLeft ? mirror(dataIn) : dataIn;

  for (genvar k = 0; k < AW; k++) begin : g_layer
    localparam int STEP = 1 << k;
    assign layer[k+1] = amount[k]
                      ? {{STEP{fillBit}}, layer[k][DW-1:STEP]}
                      : layer[k];
  end

  assign rightOut = layer[AW];

  always_comb begin
    if (!ctrl.enable)     dataOut = '0;
    else if (ctrl.toLeft) dataOut = mirror(rightOut);
    else                  dataOut = rightOut;
  end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import shifter_pkg::*;
(
  input  logic [31:0] operand,
  input  logic [4:0]  shiftCount,
  input  logic [5:0]  funcCode,
  output logic [31:0] shiftResult,
  output logic        resultValid
);
  shift_ctrl_t ctrlBus;

  shift_decode #(.FW(FUNC_W)) u_decode (
    .funcCode (funcCode),
    .ctrl     (ctrlBus)
  );

  shift_datapath #(.DW(DATA_W)) u_datapath (
    .dataIn  (operand),
    .amount  (shiftCount),
    .ctrl    (ctrlBus),
    .dataOut (shiftResult)
  );

  assign resultValid = ctrlBus.enable;
endmodule

// File: rtl/barrel_shifter_checker.sv
module barrel_shifter_checker (
  input logic [31:0] operand,
  input logic [4:0]  shiftCount,
  input logic [5:0]  funcCode,
  input logic [31:0] shiftResult,
  input logic        resultValid
);
  logic known;
  assign known = (funcCode == 6'b000000) || (funcCode == 6'b000010) ||
                 (funcCode == 6'b000011);

  always_comb begin
    AST_LEFT_LOW_ZERO: assert (!(funcCode == 6'b000000 && shiftCount != 0) || !shiftResult[0]); // R1
    AST_RIGHT_HIGH_ZERO: assert (!(funcCode == 6'b000010 && shiftCount != 0) || !shiftResult[31]); // R2
    AST_SIGN_KEPT: assert (!(funcCode == 6'b000011) || (shiftResult[31] == operand[31])); // R3
    AST_ZERO_COUNT_PASS: assert (!(resultValid && shiftCount == 0) || (shiftResult == operand)); // R4
    AST_UNKNOWN_CLEARS: assert (resultValid || (shiftResult == 32'h0)); // R5
    AST_VALID_MATCHES_CODE: assert (resultValid == known); // R6
  end
endmodule

bind barrel_shifter barrel_shifter_checker u_checker (
  .operand     (operand),
  .shiftCount  (shiftCount),
  .funcCode    (funcCode),
  .shiftResult (shiftResult),
  .resultValid (resultValid)
);

// File: tb/barrel_shifter_bench.sv
module barrel_shifter_bench;
  logic        clk = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  shiftCount = '0;
  logic [5:0]  funcCode = '0;
  logic [31:0] shiftResult;
  logic        resultValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  barrel_shifter u_barrel_shifter (
    .operand     (operand),
    .shiftCount  (shiftCount),
    .funcCode    (funcCode),
    .shiftResult (shiftResult),
    .resultValid (resultValid)
  );

  // {func[75:70], count[69:65], operand[64:33], expected[32:1], valid[0]}
  localparam logic [75:0] VECS [8] = '{
    {6'b000000, 5'd8,  32'h12345678, 32'h34567800, 1'b1},  // R7
    {6'b000010, 5'd8,  32'h12345678, 32'h00123456, 1'b1},  // R7
    {6'b000011, 5'd8,  32'h87654321, 32'hFF876543, 1'b1},  // R7
    {6'b000011, 5'd8,  32'h12345678, 32'h00123456, 1'b1},  // R3
    {6'b000000, 5'd31, 32'h00000003, 32'h80000000, 1'b1},  // R1
    {6'b000011, 5'd31, 32'h80000000, 32'hFFFFFFFF, 1'b1},  // R3
    {6'b000010, 5'd31, 32'h80000000, 32'h00000001, 1'b1},  // R2
    {6'b000001, 5'd4,  32'hFFFFFFFF, 32'h00000000, 1'b0}   // R5
  };

  task automatic apply_check(input logic [5:0] f, input logic [4:0] a,
                             input logic [31:0] v, input logic [31:0] expR,
                             input logic expV, input string tag);
    @(negedge clk);
    funcCode = f; shiftCount = a; operand = v;
    @(posedge clk); #1;
    checks++;
    if (shiftResult !== expR || resultValid !== expV) begin
      failures++;
      $display("FAIL %s func=%b count=%0d operand=%h actual=%h/%b expected=%h/%b",
               tag, f, a, v, shiftResult, resultValid, expR, expV);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] samples [3];
    samples[0] = 32'hDEADBEEF;
    samples[1] = 32'h7F00A5C3;
    samples[2] = 32'h80000001;

    // idle inputs: left shift of zero by zero (R4)
    apply_check(6'b000000, 5'd0, 32'h0, 32'h0, 1'b1, "R4 idle");

    for (int i = 0; i < 8; i++)
      apply_check(VECS[i][75:70], VECS[i][69:65], VECS[i][64:33],
                  VECS[i][32:1], VECS[i][0], "R1/R2/R3/R7 table");

    // full count sweep, R4 covers count 0 pass-through
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 32; a++) begin
        apply_check(6'b000000, a[4:0], samples[s], samples[s] << a, 1'b1, "R1 R4 left");
        apply_check(6'b000010, a[4:0], samples[s], samples[s] >> a, 1'b1, "R2 R4 right");
        apply_check(6'b000011, a[4:0], samples[s],
                    32'($signed(samples[s]) >>> a), 1'b1, "R3 R4 sign");
      end
    end

    // every other code clears result and flag (R5, R6)
    for (int f = 0; f < 64; f++) begin
      if (f != 0 && f != 2 && f != 3)
        apply_check(f[5:0], 5'd5, 32'hFFFFFFFF, 32'h0, 1'b0, "R5 R6 unknown");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule